// File: doc/BRIEF.md
# Single-Bypass Operand Interlock

This block is the hazard controller for a four-stage in-order pipeline with fetch, decode, execute and writeback stages. Only one forwarding path into decode fits in the area budget. An elaboration-time parameter chooses whether that path starts at the execute stage or at the writeback stage. The controller tracks the destination register, write-enable, load and branch flags of the instructions in execute and writeback. Each cycle it compares them with the two source registers of the instruction in decode. From that comparison it drives one operand-mux select per source, and it raises a stall when any used operand can come neither from the register file nor from the single forwarding path.

The register file is written at the end of the writeback cycle, so decode reads the new value one cycle later. With the execute-stage path, an ALU result forwards at once. A load result cannot forward from execute, because load data only arrives by writeback. With the writeback-stage path, every producer in execute forces a one-cycle wait, and any producer in writeback forwards. Fetch assumes every branch is taken. A branch in execute that resolves not-taken raises a flush, which squashes the decode instruction and overrides any stall. The block holds a small model of the execute and writeback stage registers. A stalled or squashed decode slot sends a bubble into execute.

Top module: `il_interlock`

## Requirements
- R1: After reset both tracked stages are empty: `ex_valid_o` is 0, and a decode instruction with used sources raises no stall and no forwarding select.
- R2: A source that matches no valid, writing producer in execute or writeback reads the register file (`rsN_byp_o` = 0, where 1 means the forwarding path and 0 means the register file) and causes no stall. Selects are produced whether or not `dec_valid_i` is set, but stall needs `dec_valid_i`.
- R3: With the execute-stage path, a source matching a non-load producer in execute selects forwarding without a stall.
- R4: With the execute-stage path, a source matching a load in execute stalls. It stays stalled while that load sits in writeback, and it reads the register file the cycle after.
- R5: With the execute-stage path, a source whose only match is a producer in writeback stalls for one cycle.
- R6: With the writeback-stage path, a source matching any producer in execute stalls.
- R7: With the writeback-stage path, a source whose only match is a producer in writeback, load or not, selects forwarding without a stall.
- R8: When producers in both execute and writeback target the same register, the younger one in execute alone decides the select and the stall.
- R9: Register 0, and any source whose use flag is 0, never causes a stall or a forwarding select.
- R10: A cycle with `stall_o` = 1 sends a bubble into execute (`ex_valid_o` = 0 on the next cycle).
- R11: `flush_o` is 1 exactly when execute holds a valid branch and `br_taken_i` is 0. A taken outcome raises no flush.
- R12: `flush_o` forces `stall_o` to 0, and the squashed decode instruction does not enter execute (`ex_valid_o` = 0 on the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_rs1_i | input | AW | First source register index |
| dec_rs2_i | input | AW | Second source register index |
| dec_use_rs1_i | input | 1 | First source is read by the instruction |
| dec_use_rs2_i | input | 1 | Second source is read by the instruction |
| dec_rd_i | input | AW | Destination register index |
| dec_wen_i | input | 1 | Instruction writes its destination |
| dec_load_i | input | 1 | Instruction is a load |
| dec_branch_i | input | 1 | Instruction is a conditional branch |
| br_taken_i | input | 1 | Outcome of the branch now in execute (1 = taken) |
| stall_o | output | 1 | Hold fetch and decode, bubble into execute |
| flush_o | output | 1 | Squash the fetch and decode slots |
| rs1_byp_o | output | 1 | First operand from forwarding path (1) or register file (0) |
| rs2_byp_o | output | 1 | Second operand from forwarding path (1) or register file (0) |
| ex_valid_o | output | 1 | Execute stage holds a valid instruction |

## Verification
The bench builds two copies side by side with the default 32 registers, one per forwarding source, and drives both with identical decode streams. Every dependency pattern therefore shows both outcomes at once: forwarding in one copy and stall in the other, or the two-cycle load wait against the writeback forward. A directed part covers reset, register 0, unused sources, double producers and flush over stall. A pseudo-random stream over four registers then mixes loads, branches and both branch outcomes.

// File: rtl/il_pkg.sv
package il_pkg;

  typedef enum logic { BYP_FROM_EX = 1'b0, BYP_FROM_WB = 1'b1 } byp_src_e;

  // Decide readiness of one source; returns {need_stall, take_bypass}.
  // The younger producer (execute) is consulted first.
  function automatic logic [1:0] resolve_src(input logic path_is_ex,
                                             input logic hit_ex,
                                             input logic ex_is_load,
                                             input logic hit_wb);
    logic [1:0] r;
    r = 2'b00;
    if (hit_ex) begin
      r = (path_is_ex && !ex_is_load) ? 2'b01 : 2'b10;
    end else if (hit_wb) begin
      r = path_is_ex ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

endpackage

// File: rtl/il_stage_regs.sv
module il_stage_regs #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [AW-1:0] dec_rd_i,
  input  logic          dec_wen_i,
  input  logic          dec_load_i,
  input  logic          dec_branch_i,
  output logic          ex_valid_o,
  output logic [AW-1:0] ex_rd_o,
  output logic          ex_wen_o,
  output logic          ex_load_o,
  output logic          ex_branch_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_rd_o,
  output logic          wb_wen_o
);
  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rd;
    logic          wen;
    logic          load;
    logic          branch;
  } slot_t;

  slot_t ex_q, wb_q, ex_d;

  always_comb begin
    ex_d = '0;
    if (issue_i) begin
      ex_d.valid  = 1'b1;
      ex_d.rd     = dec_rd_i;
      ex_d.wen    = dec_wen_i;
      ex_d.load   = dec_load_i;
      ex_d.branch = dec_branch_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_q <= '0;
      wb_q <= '0;
    end else begin
      ex_q <= ex_d;
      wb_q <= ex_q;
    end
  end

  assign ex_valid_o  = ex_q.valid;
  assign ex_rd_o     = ex_q.rd;
  assign ex_wen_o    = ex_q.wen;
  assign ex_load_o   = ex_q.load;
  assign ex_branch_o = ex_q.branch;
  assign wb_valid_o  = wb_q.valid;
  assign wb_rd_o     = wb_q.rd;
  assign wb_wen_o    = wb_q.wen;

  // Writeback always follows execute by one cycle.
  assert_wb_follows_ex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid_o |=> wb_valid_o);

endmodule

// File: rtl/il_src_check.sv
module il_src_check #(
  parameter int               AW         = 5,
  parameter il_pkg::byp_src_e BYPASS_SRC = il_pkg::BYP_FROM_EX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rs_i,
  input  logic          use_i,
  input  logic          ex_valid_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic          wb_valid_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wen_i,
  output logic          need_stall_o,
  output logic          take_byp_o
);
  localparam logic PATH_IS_EX = (BYPASS_SRC == il_pkg::BYP_FROM_EX);

  logic live_src, hit_ex, hit_wb;

  assign live_src = use_i && (rs_i != '0);
  assign hit_ex   = live_src && ex_valid_i && ex_wen_i && (ex_rd_i == rs_i);
  assign hit_wb   = live_src && wb_valid_i && wb_wen_i && (wb_rd_i == rs_i);

  assign {need_stall_o, take_byp_o} =
    il_pkg::resolve_src(PATH_IS_EX, hit_ex, ex_load_i, hit_wb);

  assert_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_i || rs_i == '0) |-> (!need_stall_o && !take_byp_o));

  assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(need_stall_o && take_byp_o));

  generate
    if (PATH_IS_EX) begin : g_ex_path
      assert_load_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && rs_i != '0 && ex_valid_i && ex_wen_i && ex_load_i && ex_rd_i == rs_i)
          |-> need_stall_o);
    end else begin : g_wb_path
      assert_ex_producer_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && rs_i != '0 && ex_valid_i && ex_wen_i && ex_rd_i == rs_i)
          |-> (need_stall_o && !take_byp_o));
    end
  endgenerate

endmodule

// File: rtl/il_interlock.sv
module il_interlock #(
  parameter int               NREGS      = 32,
  parameter il_pkg::byp_src_e BYPASS_SRC = il_pkg::BYP_FROM_EX,
  localparam int              AW         = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid_i,
  input  logic [AW-1:0] dec_rs1_i,
  input  logic [AW-1:0] dec_rs2_i,
  input  logic          dec_use_rs1_i,
  input  logic          dec_use_rs2_i,
  input  logic [AW-1:0] dec_rd_i,
  input  logic          dec_wen_i,
  input  logic          dec_load_i,
  input  logic          dec_branch_i,
  input  logic          br_taken_i,
  output logic          stall_o,
  output logic          flush_o,
  output logic          rs1_byp_o,
  output logic          rs2_byp_o,
  output logic          ex_valid_o
);
  localparam int NSRC = 2;

  logic          ex_valid, ex_wen, ex_load, ex_branch;
  logic [AW-1:0] ex_rd, wb_rd;
  logic          wb_valid, wb_wen;

  logic [NSRC-1:0][AW-1:0] src_idx;
  logic [NSRC-1:0]         src_use, src_stall, src_byp;

  // Named internal events, used by the checks below.
  logic any_src_wait, branch_miss, issue;

  assign src_idx = {dec_rs2_i, dec_rs1_i};
  assign src_use = {dec_use_rs2_i, dec_use_rs1_i};

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      il_src_check #(.AW(AW), .BYPASS_SRC(BYPASS_SRC)) i_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .rs_i         (src_idx[s]),
        .use_i        (src_use[s]),
        .ex_valid_i   (ex_valid),
        .ex_rd_i      (ex_rd),
        .ex_wen_i     (ex_wen),
        .ex_load_i    (ex_load),
        .wb_valid_i   (wb_valid),
        .wb_rd_i      (wb_rd),
        .wb_wen_i     (wb_wen),
        .need_stall_o (src_stall[s]),
        .take_byp_o   (src_byp[s])
      );
    end
  endgenerate

  assign any_src_wait = |src_stall;
  assign branch_miss  = ex_valid && ex_branch && !br_taken_i;
  assign stall_o      = dec_valid_i && any_src_wait && !branch_miss;
  assign flush_o      = branch_miss;
  assign issue        = dec_valid_i && !stall_o && !flush_o;
  assign rs1_byp_o    = src_byp[0];
  assign rs2_byp_o    = src_byp[1];
  assign ex_valid_o   = ex_valid;

  il_stage_regs #(.AW(AW)) i_stages (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue),
    .dec_rd_i     (dec_rd_i),
    .dec_wen_i    (dec_wen_i),
    .dec_load_i   (dec_load_i),
    .dec_branch_i (dec_branch_i),
    .ex_valid_o   (ex_valid),
    .ex_rd_o      (ex_rd),
    .ex_wen_o     (ex_wen),
    .ex_load_o    (ex_load),
    .ex_branch_o  (ex_branch),
    .wb_valid_o   (wb_valid),
    .wb_rd_o      (wb_rd),
    .wb_wen_o     (wb_wen)
  );

  assert_flush_beats_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !stall_o);

  assert_squash_no_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !ex_valid_o);

  assert_bubble_after_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !ex_valid_o);

  assert_flush_needs_branch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (ex_valid_o && !br_taken_i));

endmodule

// File: tb/test_il_interlock.sv
module test_il_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 32;
  localparam int AW         = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          dv, u1, u2, wen, ld, br, tk;
  logic [AW-1:0] rs1, rs2, rd;

  logic [4:0] out_ex, out_wb;   // {stall, flush, byp1, byp2, exv}
  logic s_e, f_e, b1_e, b2_e, v_e, s_w, f_w, b1_w, b2_w, v_w;

  il_interlock #(.NREGS(NREGS), .BYPASS_SRC(il_pkg::BYP_FROM_EX)) i_il_interlock (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dv), .dec_rs1_i(rs1), .dec_rs2_i(rs2),
    .dec_use_rs1_i(u1), .dec_use_rs2_i(u2), .dec_rd_i(rd), .dec_wen_i(wen),
    .dec_load_i(ld), .dec_branch_i(br), .br_taken_i(tk), .stall_o(s_e),
    .flush_o(f_e), .rs1_byp_o(b1_e), .rs2_byp_o(b2_e), .ex_valid_o(v_e));

  il_interlock #(.NREGS(NREGS), .BYPASS_SRC(il_pkg::BYP_FROM_WB)) i_il_interlock_wb (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dv), .dec_rs1_i(rs1), .dec_rs2_i(rs2),
    .dec_use_rs1_i(u1), .dec_use_rs2_i(u2), .dec_rd_i(rd), .dec_wen_i(wen),
    .dec_load_i(ld), .dec_branch_i(br), .br_taken_i(tk), .stall_o(s_w),
    .flush_o(f_w), .rs1_byp_o(b1_w), .rs2_byp_o(b2_w), .ex_valid_o(v_w));

  assign out_ex = {s_e, f_e, b1_e, b2_e, v_e};
  assign out_wb = {s_w, f_w, b1_w, b2_w, v_w};

  typedef struct packed {
    logic          v;
    logic [AW-1:0] rd;
    logic          w;
    logic          l;
    logic          b;
  } mslot_t;

  typedef struct packed {
    logic [4:0] e_ex;
    logic [4:0] e_wb;
    logic [7:0] req;
  } exp_t;

  exp_t   q[$];
  mslot_t mx_e, mw_e, mx_w, mw_w;
  int     n_cmp = 0, n_bad = 0;
  bit     done  = 1'b0;

  // Independent readiness model: scan producers youngest first.
  // Result: {wait, forward}.
  function automatic logic [1:0] model_src(input bit path_ex, input mslot_t young,
                                           input mslot_t old, input logic [AW-1:0] r,
                                           input logic used);
    mslot_t p;
    if (!used || r == 0) return 2'b00;
    for (int age = 0; age < 2; age++) begin
      p = (age == 0) ? young : old;
      if (p.v && p.w && p.rd == r) begin
        if (age == 0) return (path_ex && !p.l) ? 2'b01 : 2'b10;
        else          return path_ex ? 2'b10 : 2'b01;
      end
    end
    return 2'b00;
  endfunction

  // Computes one variant's outputs and advances that variant's model stages.
  task automatic model_cycle(input bit path_ex, inout mslot_t mx, inout mslot_t mw,
                             output logic [4:0] e);
    logic [1:0] a, b;
    logic fl, st;
    mslot_t nx;
    a  = model_src(path_ex, mx, mw, rs1, u1);
    b  = model_src(path_ex, mx, mw, rs2, u2);
    fl = mx.v && mx.b && (tk == 1'b0);
    st = dv && (a[1] || b[1]) && !fl;
    e  = {st, fl, a[0], b[0], mx.v};
    nx = '0;
    if (dv && !st && !fl) nx = '{v:1'b1, rd:rd, w:wen, l:ld, b:br};
    mw = mx;
    mx = nx;
  endtask

  // Driver: applies one decode cycle and pushes the expected outputs.
  task automatic step(input int req, input logic v, input int r1, input logic us1,
                      input int r2, input logic us2, input int d, input logic we,
                      input logic isl, input logic isb, input logic taken);
    exp_t x;
    @(negedge clk);
    dv = v; rs1 = AW'(r1); u1 = us1; rs2 = AW'(r2); u2 = us2;
    rd = AW'(d); wen = we; ld = isl; br = isb; tk = taken;
    model_cycle(1'b1, mx_e, mw_e, x.e_ex);
    model_cycle(1'b0, mx_w, mw_w, x.e_wb);
    x.req = 8'(req);
    q.push_back(x);
  endtask

  // Monitor: pops and compares away from the clock edge.
  initial begin
    exp_t x;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        x = q.pop_front();
        n_cmp++;
        if (out_ex !== x.e_ex) begin
          n_bad++;
          $display("FAIL R%0d ex-path {stall,flush,b1,b2,exv} actual=%b expected=%b",
                   x.req, out_ex, x.e_ex);
        end
        n_cmp++;
        if (out_wb !== x.e_wb) begin
          n_bad++;
          $display("FAIL R%0d wb-path {stall,flush,b1,b2,exv} actual=%b expected=%b",
                   x.req, out_wb, x.e_wb);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    dv = 0; rs1 = 0; rs2 = 0; u1 = 0; u2 = 0; rd = 0; wen = 0; ld = 0; br = 0; tk = 1;
    mx_e = '0; mw_e = '0; mx_w = '0; mw_w = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, no wait for a reader of x1/x2
    step(1, 1, 1, 1, 2, 1, 5, 1, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);      // R2 bubble, no dependency
    // R5 / R7: x5 producer now in writeback
    step(5, 1, 5, 1, 3, 1, 6, 1, 0, 0, 1);
    step(10, 1, 5, 1, 3, 1, 6, 1, 0, 0, 1);     // R10 repeat after stall
    step(3, 1, 6, 1, 0, 0, 7, 1, 0, 0, 1);      // R3 / R6 producer in execute
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R4: load then dependent reader, held three cycles
    step(4, 1, 1, 1, 2, 1, 8, 1, 1, 0, 1);
    step(4, 1, 3, 0, 8, 1, 9, 1, 0, 0, 1);
    step(4, 1, 3, 0, 8, 1, 9, 1, 0, 0, 1);
    step(4, 1, 3, 0, 8, 1, 9, 1, 0, 0, 1);
    step(7, 1, 9, 1, 0, 0, 10, 1, 1, 0, 1);     // R7 load in writeback for wb-path
    step(7, 1, 10, 1, 0, 0, 0, 0, 0, 0, 1);
    step(7, 1, 10, 1, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9: x0 producer and unused source
    step(9, 1, 1, 1, 1, 1, 0, 1, 0, 0, 1);
    step(9, 1, 0, 1, 0, 1, 11, 1, 0, 0, 1);
    step(9, 1, 11, 0, 11, 0, 12, 1, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R8: two producers of x13, younger decides
    step(8, 1, 0, 0, 0, 0, 13, 1, 1, 0, 1);
    step(8, 1, 0, 0, 0, 0, 13, 1, 0, 0, 1);
    step(8, 1, 13, 1, 13, 1, 14, 1, 0, 0, 1);
    step(8, 1, 13, 1, 13, 1, 14, 1, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R11: taken branch, no flush
    step(11, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1);
    step(11, 1, 2, 1, 0, 0, 15, 1, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R12: not-taken branch while decode waits on x16
    step(12, 1, 0, 0, 0, 0, 16, 1, 0, 0, 1);
    step(12, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1);
    step(12, 1, 16, 1, 0, 0, 17, 1, 0, 0, 0);
    step(12, 1, 16, 1, 0, 0, 17, 1, 0, 0, 1);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // Mixed stream over x0..x3 with loads and branches (R2, R8, R11)
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(2, lf[0] | lf[1], int'(lf[3:2]), lf[4], int'(lf[6:5]), lf[7],
           int'(lf[9:8]), lf[10], lf[11] & lf[12], lf[13] & lf[14] & ~lf[12], lf[15]);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule